// File: doc/BRIEF.md
# Bus-Clocked Power-Gate Sequencer

This block sits in the always-on domain of a receiving node and brings the node's power-gated domain up and down. It uses only rising edges of the shared bus clock and needs no local oscillator or delay element. The bus lines idle high, so a sleeping node sees no clock edges until some node starts a transaction.

The first four rising edges of every transaction are arbitration and priority edges. The receiver takes no part in them, so a gated node spends them on its four wake steps. In order, these steps turn on power, start the local oscillator, release the domain reset and remove isolation. The domain is then ready to latch the first address bit on the fifth edge.

A sleep request counts only if it is present on the edge that latches the second control bit. On that edge the domain is isolated. On the edge that returns the bus to idle, power and the oscillator are switched off and the domain reset is asserted again. The surrounding bus logic marks the transaction-start, second-control-bit and idle edges with single-cycle flags.

Top module: `psq_gate_seq`

## Requirements
- R1: With `rst` high at a rising edge of `bus_clk`, all four controls go low after that edge: power off, oscillator off, domain reset held and domain isolated.
- R2: A fully gated node that sees `txn_start` high at an edge drives `pwr_en` high and keeps the other three controls low after that edge.
- R3: The next three edges after the power-on step each advance exactly one step, whatever the marker inputs carry. They raise `osc_en`, then `rst_release`, then `iso_off`, so all four controls are high after the fourth edge of the transaction.
- R4: A fully awake node ignores `txn_start`, and all four controls stay high.
- R5: `sleep_req` is sampled only on an edge where `ctl2_edge` is high. On any other edge it has no effect.
- R6: On a `ctl2_edge` edge with `sleep_req` high, an awake node drops `iso_off` and keeps `pwr_en`, `osc_en` and `rst_release` high. It holds this state on later edges until the idle edge.
- R7: On the next `idle_edge` after R6, `pwr_en`, `osc_en` and `rst_release` all go low, which leaves the node fully gated.
- R8: If `sleep_req` is low on the `ctl2_edge` edge, the node stays fully awake through the idle edge and through the whole next transaction.
- R9: A gated node without `txn_start` stays gated, whatever `ctl2_edge`, `idle_edge` and `sleep_req` carry.
- R10: A node that has gone to sleep wakes again through the same four-step order on the next transaction.
- R11: The controls are always nested: `osc_en` implies `pwr_en`, `rst_release` implies `osc_en`, and `iso_off` implies `rst_release`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Shared bus clock; all steps occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the gated, isolated state |
| txn_start | input | 1 | High on the first (arbitration) edge of a transaction |
| ctl2_edge | input | 1 | High on the edge that latches the second control bit |
| idle_edge | input | 1 | High on the edge that returns the bus to idle |
| sleep_req | input | 1 | Request to power down the domain at the end of this transaction |
| pwr_en | output | 1 | Enables power to the gated domain |
| osc_en | output | 1 | Enables the gated domain's local oscillator |
| rst_release | output | 1 | High releases the gated domain's reset |
| iso_off | output | 1 | High removes isolation from the gated domain's outputs |

## Verification
The bench checks every step of the wake ramp edge by edge. A marker is placed on a wake edge, so a design that stalls or skips a step during wake-up leaves the domain half powered when the address bit arrives. A sleep request on an edge other than the control edge must do nothing; a design that samples it too widely would power down a node mid-transaction. The bench also sends a transaction start to a node that is already awake, which a faulty design would answer by restarting the ramp and glitching power. Finally, it checks that the idle edge removes power only after isolation is already in place. A design that reversed this order would let unpowered outputs float into the always-on logic.

// File: rtl/psq_pkg.sv
package psq_pkg;

    // Wake steps, one per protocol edge before the first address bit
    localparam int WAKE_STEPS = 4;
    localparam int STEP_W     = $clog2(WAKE_STEPS + 1);

    typedef logic [STEP_W-1:0] step_t;

    localparam step_t STEP_GATED = '0;
    localparam step_t STEP_AWAKE = step_t'(WAKE_STEPS);

    // Control bit positions in the ordered control vector
    typedef enum int {
        CTL_PWR = 0,
        CTL_OSC = 1,
        CTL_RST = 2,
        CTL_ISO = 3
    } ctl_idx_e;

    function automatic logic step_done(input step_t s);
        return s == STEP_AWAKE;
    endfunction

endpackage

// File: rtl/psq_wake_step.sv
module psq_wake_step
    import psq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  txn_start,
    input  logic  pwr_drop,
    output step_t step,
    output logic  awake
);

    step_t step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= STEP_GATED;
        end else if (step_q == STEP_GATED) begin
            if (txn_start) begin
                step_q <= step_t'(1);
            end
        end else if (!step_done(step_q)) begin
            step_q <= step_q + step_t'(1);
        end else if (pwr_drop) begin
            step_q <= STEP_GATED;
        end
    end

    assign step  = step_q;
    assign awake = step_done(step_q);

endmodule

// File: rtl/psq_sleep_ctl.sv
module psq_sleep_ctl (
    input  logic clk,
    input  logic rst,
    input  logic awake,
    input  logic ctl2_edge,
    input  logic idle_edge,
    input  logic sleep_req,
    output logic iso_hold,
    output logic pwr_drop
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (awake && hold_q && idle_edge) begin
            hold_q <= 1'b0;
        end else if (awake && ctl2_edge && sleep_req) begin
            hold_q <= 1'b1;
        end
    end

    assign iso_hold = hold_q;
    assign pwr_drop = hold_q && idle_edge;

endmodule

// File: rtl/psq_ctrl_dec.sv
module psq_ctrl_dec
    import psq_pkg::*;
(
    input  step_t                 step,
    input  logic                  iso_hold,
    output logic [WAKE_STEPS-1:0] ctrl
);

    for (genvar i = 0; i < WAKE_STEPS; i++) begin : g_ctl
        if (i == WAKE_STEPS - 1) begin : g_last
            assign ctrl[i] = (step > step_t'(i)) && !iso_hold;
        end else begin : g_mid
            assign ctrl[i] = step > step_t'(i);
        end
    end

endmodule

// File: rtl/psq_gate_seq.sv
module psq_gate_seq
    import psq_pkg::*;
(
    input  logic bus_clk,
    input  logic rst,
    input  logic txn_start,
    input  logic ctl2_edge,
    input  logic idle_edge,
    input  logic sleep_req,
    output logic pwr_en,
    output logic osc_en,
    output logic rst_release,
    output logic iso_off
);

    step_t                 step;
    logic                  awake;
    logic                  iso_hold;
    logic                  pwr_drop;
    logic [WAKE_STEPS-1:0] ctrl;

    psq_wake_step u_wake (
        .clk       (bus_clk),
        .rst       (rst),
        .txn_start (txn_start),
        .pwr_drop  (pwr_drop),
        .step      (step),
        .awake     (awake)
    );

    psq_sleep_ctl u_sleep (
        .clk       (bus_clk),
        .rst       (rst),
        .awake     (awake),
        .ctl2_edge (ctl2_edge),
        .idle_edge (idle_edge),
        .sleep_req (sleep_req),
        .iso_hold  (iso_hold),
        .pwr_drop  (pwr_drop)
    );

    psq_ctrl_dec u_dec (
        .step     (step),
        .iso_hold (iso_hold),
        .ctrl     (ctrl)
    );

    assign pwr_en      = ctrl[CTL_PWR];
    assign osc_en      = ctrl[CTL_OSC];
    assign rst_release = ctrl[CTL_RST];
    assign iso_off     = ctrl[CTL_ISO];

endmodule

// File: rtl/psq_gate_seq_chk.sv
module psq_gate_seq_chk (
    input logic bus_clk,
    input logic rst,
    input logic txn_start,
    input logic ctl2_edge,
    input logic idle_edge,
    input logic sleep_req,
    input logic pwr_en,
    input logic osc_en,
    input logic rst_release,
    input logic iso_off
);

    logic all_on;
    logic all_off;
    logic pend_q;

    assign all_on  = pwr_en && osc_en && rst_release && iso_off;
    assign all_off = !pwr_en && !osc_en && !rst_release && !iso_off;

    // Tracks an accepted sleep request from the observable ports
    always_ff @(posedge bus_clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (pend_q && idle_edge) begin
            pend_q <= 1'b0;
        end else if (all_on && ctl2_edge && sleep_req) begin
            pend_q <= 1'b1;
        end
    end

    assert_nested_R11: assert property (@(posedge bus_clk) disable iff (rst)
        (!osc_en || pwr_en) && (!rst_release || osc_en) && (!iso_off || rst_release));

    assert_first_step_R2: assert property (@(posedge bus_clk) disable iff (rst)
        all_off && txn_start |=> pwr_en && !osc_en);

    assert_osc_follows_R3: assert property (@(posedge bus_clk) disable iff (rst)
        $rose(pwr_en) |=> $rose(osc_en));

    assert_rst_follows_R3: assert property (@(posedge bus_clk) disable iff (rst)
        $rose(osc_en) |=> $rose(rst_release));

    assert_iso_follows_R3: assert property (@(posedge bus_clk) disable iff (rst)
        $rose(rst_release) |=> $rose(iso_off));

    assert_awake_holds_R4: assert property (@(posedge bus_clk) disable iff (rst)
        all_on && !(ctl2_edge && sleep_req) |=> all_on);

    assert_isolate_R6: assert property (@(posedge bus_clk) disable iff (rst)
        all_on && ctl2_edge && sleep_req |=> !iso_off && pwr_en && rst_release);

    assert_power_off_R7: assert property (@(posedge bus_clk) disable iff (rst)
        pend_q && idle_edge |=> all_off);

    assert_stay_gated_R9: assert property (@(posedge bus_clk) disable iff (rst)
        all_off && !txn_start |=> all_off);

endmodule

bind psq_gate_seq psq_gate_seq_chk u_chk (
    .bus_clk     (bus_clk),
    .rst         (rst),
    .txn_start   (txn_start),
    .ctl2_edge   (ctl2_edge),
    .idle_edge   (idle_edge),
    .sleep_req   (sleep_req),
    .pwr_en      (pwr_en),
    .osc_en      (osc_en),
    .rst_release (rst_release),
    .iso_off     (iso_off)
);

// File: tb/psq_gate_seq_tb.sv
`timescale 1ns/1ps
module psq_gate_seq_tb;

    logic bus_clk = 1'b0;
    logic rst = 1'b1;
    logic txn_start = 1'b0;
    logic ctl2_edge = 1'b0;
    logic idle_edge = 1'b0;
    logic sleep_req = 1'b0;
    logic pwr_en, osc_en, rst_release, iso_off;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 bus_clk = ~bus_clk;

    psq_gate_seq u_dut (
        .bus_clk     (bus_clk),
        .rst         (rst),
        .txn_start   (txn_start),
        .ctl2_edge   (ctl2_edge),
        .idle_edge   (idle_edge),
        .sleep_req   (sleep_req),
        .pwr_en      (pwr_en),
        .osc_en      (osc_en),
        .rst_release (rst_release),
        .iso_off     (iso_off)
    );

    // Vector order: {iso_off, rst_release, osc_en, pwr_en}
    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {iso_off, rst_release, osc_en, pwr_en};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: controls=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One bus edge with the given markers; sampled 1 ns after the edge
    task automatic tick(input logic ts, input logic c2, input logic idl, input logic sr);
        txn_start = ts; ctl2_edge = c2; idle_edge = idl; sleep_req = sr;
        @(posedge bus_clk);
        #1;
        txn_start = 1'b0; ctl2_edge = 1'b0; idle_edge = 1'b0; sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);
        rst = 1'b0;
        check("R1 reset", 4'b0000);
    endtask

    task automatic t_gated_quiet();
        tick(0, 1, 0, 1);
        check("R9 ctl2 while gated", 4'b0000);
        tick(0, 0, 1, 0);
        check("R9 idle while gated", 4'b0000);
        tick(0, 0, 0, 1);
        check("R9 sleep_req while gated", 4'b0000);
    endtask

    task automatic t_wake(input string req);
        tick(1, 0, 0, 0);
        check({req, " R2 power step"}, 4'b0001);
        tick(0, 0, 1, 1);
        check({req, " R3 osc step"}, 4'b0011);
        tick(0, 1, 0, 1);
        check({req, " R3 reset step"}, 4'b0111);
        tick(0, 0, 0, 0);
        check({req, " R3 isolation step"}, 4'b1111);
    endtask

    task automatic t_awake_ignore();
        tick(1, 0, 0, 0);
        check("R4 txn_start while awake", 4'b1111);
        tick(0, 0, 0, 1);
        check("R5 sleep_req off ctl2", 4'b1111);
        tick(0, 0, 1, 1);
        check("R5 sleep_req on idle edge", 4'b1111);
    endtask

    task automatic t_no_sleep();
        tick(0, 1, 0, 0);
        check("R8 ctl2 without request", 4'b1111);
        tick(0, 0, 0, 1);
        check("R5 late request", 4'b1111);
        tick(0, 0, 1, 0);
        check("R8 idle edge", 4'b1111);
        tick(1, 0, 0, 0);
        for (int i = 0; i < 5; i++) tick(0, 0, 0, 0);
        check("R8 next transaction", 4'b1111);
    endtask

    task automatic t_sleep();
        tick(0, 1, 0, 1);
        check("R6 isolate on ctl2", 4'b0111);
        tick(0, 0, 0, 0);
        check("R6 hold isolated", 4'b0111);
        tick(0, 0, 1, 0);
        check("R7 power off on idle", 4'b0000);
        tick(0, 0, 1, 0);
        check("R9 stays gated", 4'b0000);
    endtask

    task automatic t_reset_awake();
        rst = 1'b1;
        tick(0, 0, 0, 0);
        rst = 1'b0;
        check("R1 reset from awake", 4'b0000);
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_gated_quiet();
        t_wake("first");
        t_awake_ignore();
        t_no_sleep();
        t_sleep();
        t_wake("R10 rewake");
        t_reset_awake();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule